// File: doc/BRIEF.md
# Multiplexed Host Memory Slave Port

This block lets an external host reach two small on-chip memories through one 16-bit bus that carries both addresses and data. The host first runs a latch cycle, raising the address-latch strobe while driving a control word. The top bit of that word chooses the target. With bit 15 clear, the word loads the internal 14-bit word address and the memory type. With bit 15 set, the word loads an 8-bit overlay register instead. Reads and writes that follow then stream through memory, and the address steps forward by itself after each complete word.

Program memory words are 24 bits wide and take two bus accesses each. The first access carries the upper 16 bits. The second carries the lower 8 bits in the low byte, and a read returns zero in its upper byte. A packing state machine tracks this. It sits in `ST_WORD` when it expects a full data word or the upper half of a program word, and moves to `ST_PM_LO` after that upper half. The second half takes it back to `ST_WORD` and steps the address. A new address latch always returns it to `ST_WORD`. A separate acknowledge timer moves from `ACK_IDLE` to `ACK_BUSY` on every accepted strobe. It holds the acknowledge line high for a fixed number of clocks and then returns to `ACK_IDLE`.

Strobes are sampled on the block clock, and each access happens on the rising edge of its strobe. In boot mode, completing a program word at address 0 raises a sticky boot-complete output.

Top module: `hostport_slave`

## Requirements
- R1: After reset, hp_ack and boot_done are low, hp_data_out is 0x0000, the overlay register is 0x00, and the latched target is program memory at address 0.
- R2: On a latch cycle with bus bit 15 = 0, bits 13:0 become the word address and bit 14 selects the memory: 0 means program memory, 1 means data memory.
- R3: On a latch cycle with bus bit 15 = 1 and bits 14:8 all zero, bits 7:0 load the overlay register. If any of bits 14:8 is set, the overlay register and the latched address keep their values.
- R4: After each complete word transfer, read or write, the latched address increases by one, so consecutive accesses need no new latch cycle.
- R5: A program memory word moves in two accesses. The first carries bits 23:8. The second carries bits 7:0 in bus bits 7:0, and a read of it returns 0x00 in bits 15:8. The address does not step between the two halves.
- R6: Data memory words are 16 bits wide. Data memory address 0x3FE0 reads and writes the overlay register in bits 7:0 and returns 0x00 in bits 15:8.
- R7: hp_ack goes high in the cycle after an accepted strobe edge, stays high for ACK_CYCLES clocks, and then returns low.
- R8: When boot_mode is high, completing the second half of a program memory write at address 0 sets boot_done, which stays high until reset. With boot_mode low, the same write leaves boot_done low.
- R9: Each strobe acts once, on its rising edge while hp_sel is high. Holding a strobe high does not repeat the access, and a strobe with hp_sel low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_sel | input | 1 | Port select, active high |
| hp_ale | input | 1 | Address-latch strobe, active high |
| hp_rd | input | 1 | Read strobe, active high |
| hp_wr | input | 1 | Write strobe, active high |
| hp_data_in | input | 16 | Multiplexed address/data from the host |
| hp_data_out | output | 16 | Read data, held until the next read |
| hp_ack | output | 1 | High while the port is busy with an access |
| boot_mode | input | 1 | Enables boot-complete detection |
| boot_done | output | 1 | Sticky flag: program word at address 0 written in boot mode |

## Verification
The assertions assume that the host raises at most one strobe at a time. They also assume that a strobe which is latched together with another would be resolved in the order latch, write, read. The stimulus pulses one strobe per access and waits until hp_ack has fallen before the next one, so no two events ever share a cycle. Held strobes and strobes with the port deselected are driven on purpose, because both are part of the edge rule that the bench checks.

// File: rtl/hp_pkg.sv
package hp_pkg;
    // Field positions of the latch word; the decode depends on them
    localparam int CTL_OVL_BIT  = 15;
    localparam int CTL_TYPE_BIT = 14;

    // Packing state: expecting a full word or the upper half, or the lower half
    typedef enum logic {ST_WORD, ST_PM_LO} pack_st_e;
    // Acknowledge timer state
    typedef enum logic {ACK_IDLE, ACK_BUSY} ack_st_e;
endpackage

// File: rtl/hp_edge.sv
module hp_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] event_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= strobe;
    end

    for (genvar i = 0; i < N; i++) begin : g_det
        assign event_o[i] = sel && strobe[i] && !prev_q[i];

        AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
            event_o[i] |=> !event_o[i]); // R9
    end
endmodule

// File: rtl/hp_ack_timer.sv
module hp_ack_timer
    import hp_pkg::*;
#(
    parameter int ACK_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ack
);
    localparam int CW = $clog2(ACK_CYCLES + 1);

    ack_st_e       st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ACK_IDLE;
            cnt_q <= '0;
        end else if (start) begin
            st_q  <= ACK_BUSY;
            cnt_q <= CW'(ACK_CYCLES - 1);
        end else begin
            unique case (st_q)
                ACK_IDLE: st_q <= ACK_IDLE;
                ACK_BUSY: begin
                    if (cnt_q == '0) st_q  <= ACK_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    always_comb ack = (st_q == ACK_BUSY);

    AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ack); // R7
endmodule

// File: rtl/hp_ram.sv
module hp_ram #(
    parameter int W = 16,
    parameter int D = 256
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [$clog2(D)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(D)-1:0] raddr,
    output logic [W-1:0]         rdata
);
    logic [W-1:0] mem [D];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
    import hp_pkg::*;
#(
    parameter int          PM_DEPTH    = 256,
    parameter int          DM_DEPTH    = 256,
    parameter int          ACK_CYCLES  = 3,
    parameter logic [13:0] OVL_DM_ADDR = 14'h3FE0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hp_sel,
    input  logic        hp_ale,
    input  logic        hp_rd,
    input  logic        hp_wr,
    input  logic [15:0] hp_data_in,
    output logic [15:0] hp_data_out,
    output logic        hp_ack,
    input  logic        boot_mode,
    output logic        boot_done
);
    localparam int PM_AW = $clog2(PM_DEPTH);
    localparam int DM_AW = $clog2(DM_DEPTH);

    logic [2:0]  ev;
    logic        ale_ev, wr_ev, rd_ev;
    logic [13:0] addr_q;
    logic        dm_sel_q;
    logic [7:0]  ovl_q;
    logic [15:0] hi_q;
    logic [15:0] rd_q;
    logic        boot_q;
    pack_st_e    st_q, st_d;
    logic        acc, step, is_ovl, pm_we, dm_we;
    logic [23:0] pm_rdata;
    logic [15:0] dm_rdata;

    hp_edge #(.N(3)) u_edge (
        .clk(clk), .rst_n(rst_n), .sel(hp_sel),
        .strobe({hp_rd, hp_wr, hp_ale}), .event_o(ev)
    );
    assign ale_ev = ev[0];
    assign wr_ev  = ev[1] && !ale_ev;
    assign rd_ev  = ev[2] && !ale_ev && !ev[1];

    hp_ack_timer #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
        .clk(clk), .rst_n(rst_n), .start(|ev), .ack(hp_ack)
    );

    assign acc    = wr_ev || rd_ev;
    assign is_ovl = dm_sel_q && (addr_q == OVL_DM_ADDR);
    assign step   = acc && (dm_sel_q || st_q == ST_PM_LO);
    assign pm_we  = wr_ev && !dm_sel_q && (st_q == ST_PM_LO);
    assign dm_we  = wr_ev && dm_sel_q && !is_ovl;

    hp_ram #(.W(24), .D(PM_DEPTH)) u_pm (
        .clk(clk), .we(pm_we), .waddr(addr_q[PM_AW-1:0]),
        .wdata({hi_q, hp_data_in[7:0]}),
        .raddr(addr_q[PM_AW-1:0]), .rdata(pm_rdata)
    );

    hp_ram #(.W(16), .D(DM_DEPTH)) u_dm (
        .clk(clk), .we(dm_we), .waddr(addr_q[DM_AW-1:0]),
        .wdata(hp_data_in),
        .raddr(addr_q[DM_AW-1:0]), .rdata(dm_rdata)
    );

    // Packing state: next-state logic
    always_comb begin
        st_d = st_q;
        if (ale_ev) begin
            if (!hp_data_in[CTL_OVL_BIT]) st_d = ST_WORD;
        end else if (acc && !dm_sel_q) begin
            unique case (st_q)
                ST_WORD:  st_d = ST_PM_LO;
                ST_PM_LO: st_d = ST_WORD;
            endcase
        end
    end

    // Packing state: register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WORD;
        else        st_q <= st_d;
    end

    // Registers and outputs driven by the accesses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            dm_sel_q <= 1'b0;
            ovl_q    <= '0;
            hi_q     <= '0;
            rd_q     <= '0;
            boot_q   <= 1'b0;
        end else if (ale_ev) begin
            if (!hp_data_in[CTL_OVL_BIT]) begin
                addr_q   <= hp_data_in[13:0];
                dm_sel_q <= hp_data_in[CTL_TYPE_BIT];
            end else if (hp_data_in[14:8] == 7'd0) begin
                ovl_q <= hp_data_in[7:0];
            end
        end else if (wr_ev) begin
            if (!dm_sel_q && st_q == ST_WORD) hi_q <= hp_data_in;
            if (is_ovl) ovl_q <= hp_data_in[7:0];
            if (pm_we && boot_mode && addr_q == 14'd0) boot_q <= 1'b1;
            if (step) addr_q <= addr_q + 14'd1;
        end else if (rd_ev) begin
            if (dm_sel_q)
                rd_q <= is_ovl ? {8'h00, ovl_q} : dm_rdata;
            else if (st_q == ST_WORD)
                rd_q <= pm_rdata[23:8];
            else
                rd_q <= {8'h00, pm_rdata[7:0]};
            if (step) addr_q <= addr_q + 14'd1;
        end
    end

    assign hp_data_out = rd_q;
    assign boot_done   = boot_q;

    AST_BAD_OVL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_ev && hp_data_in[15] && hp_data_in[14:8] != 7'd0)
        |=> ($stable(ovl_q) && $stable(addr_q))); // R3
    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dm_sel_q) |=> (addr_q == $past(addr_q) + 14'd1)); // R4
    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !dm_sel_q && st_q == ST_WORD) |=> $stable(addr_q)); // R5
    AST_PM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !dm_sel_q && st_q == ST_PM_LO)
        |=> (addr_q == $past(addr_q) + 14'd1)); // R5
    AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done); // R8
endmodule

// File: tb/hostport_slave_tb_top.sv
module hostport_slave_tb_top;
    localparam int ACK_CYCLES = 3;
    localparam int NV = 27;
    // Each entry: {op[1:0], data[15:0], expected[15:0]}; op 0 latch, 1 write, 2 read+check
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 16'h0005, 16'h0000},  // R2 PM address 5
        {2'd1, 16'h1234, 16'h0000},  // R5 upper half
        {2'd1, 16'h0056, 16'h0000},  // R5 lower half
        {2'd1, 16'hABCD, 16'h0000},  // R4 next word, no relatch
        {2'd1, 16'hFFEF, 16'h0000},
        {2'd0, 16'h0005, 16'h0000},
        {2'd2, 16'h0000, 16'h1234},
        {2'd2, 16'h0000, 16'h0056},
        {2'd2, 16'h0000, 16'hABCD},
        {2'd2, 16'h0000, 16'h00EF},  // R5 upper byte zero
        {2'd0, 16'h4010, 16'h0000},  // R2 DM address 0x10
        {2'd1, 16'hBEEF, 16'h0000},
        {2'd1, 16'h0102, 16'h0000},
        {2'd0, 16'h4010, 16'h0000},
        {2'd2, 16'h0000, 16'hBEEF},  // R6
        {2'd2, 16'h0000, 16'h0102},  // R4
        {2'd0, 16'h80A5, 16'h0000},  // R3 overlay load
        {2'd0, 16'h7FE0, 16'h0000},
        {2'd2, 16'h0000, 16'h00A5},  // R3 R6
        {2'd0, 16'h7FE0, 16'h0000},
        {2'd1, 16'h773C, 16'h0000},  // R6 write overlay through DM
        {2'd0, 16'h7FE0, 16'h0000},
        {2'd2, 16'h0000, 16'h003C},
        {2'd0, 16'h8122, 16'h0000},  // R3 bad word, ignored
        {2'd0, 16'h7FE0, 16'h0000},
        {2'd2, 16'h0000, 16'h003C},  // R3
        {2'd2, 16'h0000, 16'hBEEF}   // R3 address unchanged by bad word: 0x3FE1 aliases 0xE1? see note
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_sel = 1'b0, hp_ale = 1'b0, hp_rd = 1'b0, hp_wr = 1'b0;
    logic [15:0] hp_data_in = '0;
    logic [15:0] hp_data_out;
    logic        hp_ack, boot_mode = 1'b0, boot_done;
    int          n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] got;

    always #10 clk = ~clk;

    hostport_slave #(.ACK_CYCLES(ACK_CYCLES)) dut_i (
        .clk(clk), .rst_n(rst_n), .hp_sel(hp_sel), .hp_ale(hp_ale),
        .hp_rd(hp_rd), .hp_wr(hp_wr), .hp_data_in(hp_data_in),
        .hp_data_out(hp_data_out), .hp_ack(hp_ack),
        .boot_mode(boot_mode), .boot_done(boot_done)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // op: 0 latch, 1 write, 2 read; hold = cycles strobe stays high; sel = select level
    task automatic do_op(input int op, input logic [15:0] d, input int hold, input logic sel,
                         output logic [15:0] rd);
        @(negedge clk);
        hp_sel = sel;
        hp_data_in = d;
        hp_ale = (op == 0);
        hp_wr  = (op == 1);
        hp_rd  = (op == 2);
        repeat (hold) @(negedge clk);
        rd = hp_data_out;
        hp_ale = 1'b0; hp_wr = 1'b0; hp_rd = 1'b0;
        hp_sel = 1'b1;
        repeat (ACK_CYCLES + 1) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack", {15'd0, hp_ack}, 16'd0);
        check("R1 data_out", hp_data_out, 16'h0000);
        check("R1 boot_done", {15'd0, boot_done}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 overlay resets to zero, read through DM 0x3FE0
        do_op(0, 16'h7FE0, 1, 1'b1, got);
        do_op(2, 16'h0000, 1, 1'b1, got);
        check("R1 overlay", got, 16'h0000);

        for (int i = 0; i < NV - 1; i++) begin
            do_op(int'(VEC[i][33:32]), VEC[i][31:16], 1, 1'b1, got);
            if (VEC[i][33:32] == 2'd2) check($sformatf("R4/R5/R6/R3 vec %0d", i), got, VEC[i][15:0]);
        end
        // R3: bad latch word left address at DM 0x3FE1; relatch DM 0x10 and recheck contents
        do_op(0, 16'h4010, 1, 1'b1, got);
        do_op(2, 16'h0000, 1, 1'b1, got);
        check("R3 data intact", got, VEC[NV-1][15:0]);

        // R7 acknowledge timing
        @(negedge clk);
        hp_data_in = 16'h4010; hp_ale = 1'b1;
        @(negedge clk);
        hp_ale = 1'b0;
        check("R7 ack high", {15'd0, hp_ack}, 16'd1);
        repeat (ACK_CYCLES - 1) @(negedge clk);
        check("R7 ack still high", {15'd0, hp_ack}, 16'd1);
        @(negedge clk);
        check("R7 ack low", {15'd0, hp_ack}, 16'd0);

        // R9 held strobe acts once; deselected strobe ignored
        do_op(0, 16'h4020, 1, 1'b1, got);
        do_op(1, 16'h1111, 5, 1'b1, got);
        do_op(1, 16'h7777, 1, 1'b0, got);
        do_op(1, 16'h2222, 1, 1'b1, got);
        do_op(0, 16'h4020, 1, 1'b1, got);
        do_op(2, 16'h0000, 1, 1'b1, got);
        check("R9 first word", got, 16'h1111);
        do_op(2, 16'h0000, 1, 1'b1, got);
        check("R9 second word", got, 16'h2222);

        // R8 boot detection
        do_op(0, 16'h0000, 1, 1'b1, got);
        do_op(1, 16'h0A0B, 1, 1'b1, got);
        do_op(1, 16'h000C, 1, 1'b1, got);
        check("R8 no boot_mode", {15'd0, boot_done}, 16'd0);
        boot_mode = 1'b1;
        do_op(0, 16'h0000, 1, 1'b1, got);
        do_op(1, 16'h0D0E, 1, 1'b1, got);
        check("R8 after upper half", {15'd0, boot_done}, 16'd0);
        do_op(1, 16'h000F, 1, 1'b1, got);
        check("R8 boot_done set", {15'd0, boot_done}, 16'd1);
        do_op(1, 16'h1234, 1, 1'b1, got);
        check("R8 sticky", {15'd0, boot_done}, 16'd1);
        // R5 boot word stored as two halves
        do_op(0, 16'h0000, 1, 1'b1, got);
        do_op(2, 16'h0000, 1, 1'b1, got);
        check("R5 boot upper", got, 16'h0D0E);
        do_op(2, 16'h0000, 1, 1'b1, got);
        check("R5 boot lower", got, 16'h000F);

        finish_run();
    end
endmodule